// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

This block is one 8-bit timer channel: an up counter, a comparator and a write-only compare register with an optional staging stage in front of it. Software writes a compare value through a single write strobe. A control bit selects whether that write takes effect at once or is held in the staging register. In the held case, the channel copies the value into the live compare register only at a point in the count cycle where the change cannot cut a period short.

A mode input selects one of three behaviours. In plain timer mode the counter restarts after each compare hit. In PWM mode the counter runs freely over a selectable 6-, 7- or 8-bit range. In PPG mode the counter restarts on the compare hit, and that hit is also the point where staged data is applied. The block reports a compare-hit pulse and a counter-overflow pulse. A count tick, which comes from an external prescaler, paces the counter.

Top module: `tmr_dbuf_top`

## Requirements
- R1: While the live compare value is nonzero, a tick taken with the counter equal to that value yields a one-cycle `match_o` pulse in the following cycle.
- R2: While the live compare value is 00H, `match_o` pulses together with the overflow event instead of on equality.
- R3: The overflow event is a tick taken with the counter at FFH in timer or PPG mode, or with the low n counter bits all ones in PWM mode. It yields a one-cycle `ovf_o` pulse in the following cycle. The `pwm_sel` input selects n: 0 gives 6, 1 gives 7, and 2 or 3 give 8.
- R4: The buffer-enable bit is 0 after reset. A cycle with `ctl_wr` high loads it from `ctl_dbuf`.
- R5: With buffer-enable at 0, a write (`wr_en` high) loads `wr_data` into both the staging register and the live compare register.
- R6: With buffer-enable at 1, a write loads only the staging register, and the live compare value is unchanged by it.
- R7: In PWM mode (`mode`=1) with buffer-enable at 1, the staging value moves to the live register on each overflow event.
- R8: In PPG mode (`mode`=2) with buffer-enable at 1, the staging value moves to the live register on each compare hit taken with a tick.
- R9: In timer mode (`mode`=0, and the spare code 3, which also runs as a timer), no staging-to-live transfer ever happens.
- R10: When a write and a transfer fall in the same cycle, the live register receives the old staging value and the staging register receives the new write.
- R11: In timer and PPG modes the counter returns to 0 on a tick that produces a compare hit. In PWM mode it wraps freely at 2^n and a hit does not restart it.
- R12: Reset (synchronous, `rst_n` low at a clock edge) clears the counter, both compare registers and both pulse outputs.
- R13: The counter advances only on cycles with `tick` high. Cycles without a tick hold the count and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| mode | input | 2 | 0 timer, 1 PWM, 2 PPG, 3 timer |
| pwm_sel | input | SELW (2) | PWM width: 0 six bits, 1 seven bits, 2/3 eight bits |
| ctl_wr | input | 1 | Loads the buffer-enable bit |
| ctl_dbuf | input | 1 | New buffer-enable value |
| wr_en | input | 1 | Compare register write strobe |
| wr_data | input | CW (8) | Compare write data |
| match_o | output | 1 | Compare-hit pulse |
| ovf_o | output | 1 | Counter-overflow pulse |

## Verification
The hardest case to reach from the ports is a write that lands in the exact cycle of a staging-to-live transfer. The compare registers cannot be read, so that cycle is invisible from outside. The bench runs a cycle-true model beside the design and watches the model's counter at each falling edge. When the model shows that the next tick is a PWM overflow or a PPG compare hit, the bench raises the write strobe in that same cycle. The outcome is then checked through the spacing of later `match_o` pulses, together with an exhaustive sweep of every compare value in timer mode under several tick patterns.

// File: rtl/tmr_dbuf_pkg.sv
// Shared types for the double-buffered timer compare unit.
// Assumes a two-bit mode field; code 3 is spare and runs as plain timer.
package tmr_dbuf_pkg;

    typedef enum logic [1:0] {
        TM_TIMER = 2'd0,
        TM_PWM   = 2'd1,
        TM_PPG   = 2'd2,
        TM_SPARE = 2'd3
    } tmr_mode_e;

endpackage

// File: rtl/tmr_upcount.sv
// Up counter of the timer channel.
// Advances on tick. In free-run (PWM) mode it wraps inside the supplied
// mask. Otherwise it clears on a compare hit and wraps at full width.
// Assumes wrap_mask is of the form 2^n-1.
module tmr_upcount #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          free_run,
    input  logic          hit_clr,
    input  logic [CW-1:0] wrap_mask,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_inc;

    // next count without restart
    always_comb begin
        cnt_inc = cnt + CW'(1);
    end

    // count register: hold, wrap in mask, or clear on hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (free_run) begin
                cnt <= cnt_inc & wrap_mask;
            end else if (hit_clr) begin
                cnt <= '0;
            end else begin
                cnt <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/tmr_cmp_store.sv
// Compare value storage: staging register, live register, buffer-enable bit.
// A write always fills staging. The live register takes the write directly
// while buffering is off, and otherwise takes staging on a transfer strobe.
// A same-cycle transfer moves the old staging value.
module tmr_cmp_store #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_dbuf,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          xfer,
    output logic          dbuf_q,
    output logic [CW-1:0] stage_q,
    output logic [CW-1:0] act_q
);

    // buffer-enable control bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbuf_q <= 1'b0;
        end else if (ctl_wr) begin
            dbuf_q <= ctl_dbuf;
        end
    end

    // staging register follows every bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en) begin
            stage_q <= wr_data;
        end
    end

    // live compare register: direct write or staged transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (wr_en && !dbuf_q) begin
            act_q <= wr_data;
        end else if (xfer) begin
            act_q <= stage_q;
        end
    end

endmodule

// File: rtl/tmr_evt_detect.sv
// Event detection for the timer channel.
// Builds the PWM wrap mask from the width select, detects the overflow
// point and the compare hit, raises the transfer strobe, and registers the
// one-cycle match and overflow pulses. Select codes past the last width map
// to full width.
module tmr_evt_detect
    import tmr_dbuf_pkg::*;
#(
    parameter int CW        = 8,
    parameter int PWM_MIN_W = 6,
    parameter int NSEL      = CW - PWM_MIN_W + 1,
    parameter int SELW      = (NSEL > 1) ? $clog2(NSEL) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  tmr_mode_e       mode_e,
    input  logic [SELW-1:0] pwm_sel,
    input  logic            dbuf_q,
    input  logic [CW-1:0]   cnt,
    input  logic [CW-1:0]   act_q,
    output logic [CW-1:0]   wrap_mask,
    output logic            free_run,
    output logic            hit,
    output logic            xfer,
    output logic            match_o,
    output logic            ovf_o
);

    localparam logic [CW-1:0] FULL = {CW{1'b1}};

    logic [CW-1:0] mask_tab [NSEL];
    logic          top_hit;
    logic          is_ppg;

    // one mask per selectable PWM width
    for (genvar g = 0; g < NSEL; g++) begin : g_mask
        assign mask_tab[g] = CW'((64'd1 << (PWM_MIN_W + g)) - 64'd1);
    end

    // pick the mask for the selected width, full width otherwise
    always_comb begin
        wrap_mask = FULL;
        for (int i = 0; i < NSEL; i++) begin
            if (pwm_sel == SELW'(i)) begin
                wrap_mask = mask_tab[i];
            end
        end
    end

    // mode decode
    always_comb begin
        free_run = (mode_e == TM_PWM);
        is_ppg   = (mode_e == TM_PPG);
    end

    // overflow point, compare hit and transfer strobe
    always_comb begin
        if (free_run) begin
            top_hit = ((cnt & wrap_mask) == wrap_mask);
        end else begin
            top_hit = (cnt == FULL);
        end
        hit  = (act_q == '0) ? top_hit : (cnt == act_q);
        xfer = tick && dbuf_q && ((free_run && top_hit) || (is_ppg && hit));
    end

    // registered single-cycle output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            match_o <= tick && hit;
            ovf_o   <= tick && top_hit;
        end
    end

endmodule

// File: rtl/tmr_dbuf_top.sv
// Top of the double-buffered timer compare unit.
// Connects the compare storage, the event detector and the up counter.
// Assumes tick is already synchronous to clk and one cycle wide per count.
module tmr_dbuf_top
    import tmr_dbuf_pkg::*;
#(
    parameter int CW        = 8,
    parameter int PWM_MIN_W = 6,
    parameter int NSEL      = CW - PWM_MIN_W + 1,
    parameter int SELW      = (NSEL > 1) ? $clog2(NSEL) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [1:0]      mode,
    input  logic [SELW-1:0] pwm_sel,
    input  logic            ctl_wr,
    input  logic            ctl_dbuf,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_data,
    output logic            match_o,
    output logic            ovf_o
);

    tmr_mode_e     mode_e;
    logic          dbuf_q;
    logic [CW-1:0] stage_q;
    logic [CW-1:0] act_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wrap_mask;
    logic          free_run;
    logic          hit;
    logic          xfer;

    // mode field to enum
    always_comb begin
        mode_e = tmr_mode_e'(mode);
    end

    tmr_cmp_store #(.CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .ctl_dbuf(ctl_dbuf),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .xfer    (xfer),
        .dbuf_q  (dbuf_q),
        .stage_q (stage_q),
        .act_q   (act_q)
    );

    tmr_evt_detect #(
        .CW       (CW),
        .PWM_MIN_W(PWM_MIN_W),
        .NSEL     (NSEL),
        .SELW     (SELW)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode_e   (mode_e),
        .pwm_sel  (pwm_sel),
        .dbuf_q   (dbuf_q),
        .cnt      (cnt),
        .act_q    (act_q),
        .wrap_mask(wrap_mask),
        .free_run (free_run),
        .hit      (hit),
        .xfer     (xfer),
        .match_o  (match_o),
        .ovf_o    (ovf_o)
    );

    tmr_upcount #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .free_run (free_run),
        .hit_clr  (hit),
        .wrap_mask(wrap_mask),
        .cnt      (cnt)
    );

endmodule

// File: rtl/tmr_dbuf_chk.sv
// Property checker for tmr_dbuf_top, bound to every instance.
// Observes the ports plus the storage, counter and transfer strobe.
module tmr_dbuf_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    mode,
    input logic          wr_en,
    input logic [CW-1:0] wr_data,
    input logic          dbuf_q,
    input logic [CW-1:0] stage_q,
    input logic [CW-1:0] act_q,
    input logic [CW-1:0] cnt,
    input logic          xfer,
    input logic          match_o,
    input logic          ovf_o
);

    // R12: reset clears state and pulses
    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && act_q == '0 && stage_q == '0 && !match_o && !ovf_o));

    // R4: buffering off after reset
    a_r4_dbuf_reset: assert property (@(posedge clk)
        !rst_n |=> !dbuf_q);

    // R1: nonzero equality produces a pulse
    a_r1_match_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && act_q != '0 && cnt == act_q) |=> match_o);

    // R5: direct write reaches the live register
    a_r5_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dbuf_q) |=> (act_q == $past(wr_data)));

    // R6: every write fills staging
    a_r6_stage_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (stage_q == $past(wr_data)));

    // R9: timer mode never changes a buffered live value
    a_r9_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd1 && mode != 2'd2 && dbuf_q && !wr_en) |=> $stable(act_q));

    // R10: collision moves the old staging value
    a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dbuf_q && xfer) |=> (act_q == $past(stage_q)));

    // R13: no tick, no count change and no pulse
    a_r13_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && !match_o && !ovf_o));

endmodule

bind tmr_dbuf_top tmr_dbuf_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .mode   (mode),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .dbuf_q (dbuf_q),
    .stage_q(stage_q),
    .act_q  (act_q),
    .cnt    (cnt),
    .xfer   (xfer),
    .match_o(match_o),
    .ovf_o  (ovf_o)
);

// File: tb/tb_tmr_dbuf_top.sv
module tb_tmr_dbuf_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int SELW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic [1:0]      mode = 2'd0;
    logic [SELW-1:0] pwm_sel = '0;
    logic            ctl_wr = 1'b0;
    logic            ctl_dbuf = 1'b0;
    logic            wr_en = 1'b0;
    logic [CW-1:0]   wr_data = '0;
    logic            match_o;
    logic            ovf_o;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R12";
    logic  cmp_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state, built from the requirements
    logic [7:0] m_cnt, m_act, m_buf;
    logic       m_dbuf, m_match, m_ovf;

    tmr_dbuf_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .pwm_sel(pwm_sel),
        .ctl_wr(ctl_wr), .ctl_dbuf(ctl_dbuf), .wr_en(wr_en), .wr_data(wr_data),
        .match_o(match_o), .ovf_o(ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // cycle model of the requirements
    always @(posedge clk) begin
        int   nbits;
        logic [7:0] mk;
        logic top, hitv, xf;
        if (!rst_n) begin
            m_cnt <= 0; m_act <= 0; m_buf <= 0; m_dbuf <= 0; m_match <= 0; m_ovf <= 0;
        end else begin
            nbits = (pwm_sel == 0) ? 6 : (pwm_sel == 1) ? 7 : 8;
            mk    = 8'((1 << nbits) - 1);
            top   = (mode == 2'd1) ? ((m_cnt & mk) == mk) : (m_cnt == 8'hFF);
            hitv  = (m_act == 0) ? top : (m_cnt == m_act);
            xf    = tick && m_dbuf && ((mode == 2'd1 && top) || (mode == 2'd2 && hitv));
            m_match <= tick && hitv;
            m_ovf   <= tick && top;
            if (tick) begin
                if (mode == 2'd1) m_cnt <= (m_cnt + 8'd1) & mk;
                else if (hitv)    m_cnt <= 0;
                else              m_cnt <= m_cnt + 8'd1;
            end
            if (wr_en) m_buf <= wr_data;
            if (wr_en && !m_dbuf) m_act <= wr_data;
            else if (xf)          m_act <= m_buf;
            if (ctl_wr) m_dbuf <= ctl_dbuf;
        end
    end

    // compare outputs away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            checks += 2;
            if (match_o !== m_match) begin
                errors++;
                $display("FAIL %s match_o act=%b exp=%b t=%0t", cur_tag, match_o, m_match, $time);
            end
            if (ovf_o !== m_ovf) begin
                errors++;
                $display("FAIL %s ovf_o act=%b exp=%b t=%0t", cur_tag, ovf_o, m_ovf, $time);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; ctl_wr = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (match_o !== 1'b0 || ovf_o !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset outputs act=%b%b exp=00", match_o, ovf_o);
        end
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_dbuf(input logic b);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_dbuf = b;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // pat 0: every cycle, 1: every other, 2: pseudo-random
    task automatic run(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (pat)
                0: tick = 1'b1;
                1: tick = i[0];
                default: tick = lfsr[0];
            endcase
        end
    endtask

    initial begin
        cmp_on = 1'b1;

        // R12 R2 R3: reset state, zero compare in timer mode
        cur_tag = "R12 R2 R3";
        do_reset();
        mode = 2'd0;
        run(600, 0);

        // R1 R11 R5 R13: every compare value in timer mode
        for (int v = 1; v < 256; v++) begin
            cur_tag = "R1 R11 R5 R13";
            do_reset();
            mode = 2'd0;
            bus_wr(8'(v));
            run(2 * v + 12, v % 3);
        end

        // R4 R6 R9: buffered write has no effect in timer mode (also code 3)
        cur_tag = "R4 R6 R9";
        do_reset();
        mode = 2'd0;
        bus_wr(8'd10);
        set_dbuf(1'b1);
        bus_wr(8'd50);
        run(300, 0);
        mode = 2'd3;
        bus_wr(8'd3);
        run(300, 2);

        // R4: buffering off again after reset, so a write acts at once
        cur_tag = "R4 R5";
        do_reset();
        mode = 2'd0;
        bus_wr(8'd20);
        run(100, 0);

        // R7 R3 R2 R11: PWM at each width select
        for (int s = 0; s < 4; s++) begin
            cur_tag = "R7 R3 R2 R11";
            do_reset();
            mode = 2'd1; pwm_sel = SELW'(s);
            bus_wr(8'd30);
            set_dbuf(1'b1);
            bus_wr(8'd40);
            run(700, 0);
            bus_wr(8'd0);
            run(600, (s == 3) ? 2 : 0);
        end

        // R8: PPG transfer at the compare hit
        cur_tag = "R8 R11";
        do_reset();
        mode = 2'd2;
        bus_wr(8'd20);
        set_dbuf(1'b1);
        bus_wr(8'd60);
        run(200, 0);
        bus_wr(8'd5);
        run(200, 1);

        // R10: write lands in the PPG transfer cycle
        cur_tag = "R10";
        do_reset();
        mode = 2'd2;
        bus_wr(8'd20);
        set_dbuf(1'b1);
        bus_wr(8'd30);
        tick = 1'b1;
        @(negedge clk);
        while (m_cnt != m_act) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'd70;
        @(negedge clk);
        wr_en = 1'b0;
        run(300, 0);

        // R10: write lands in the PWM transfer cycle
        do_reset();
        mode = 2'd1; pwm_sel = 2'd0;
        bus_wr(8'd10);
        set_dbuf(1'b1);
        bus_wr(8'd25);
        tick = 1'b1;
        @(negedge clk);
        while (m_cnt != 8'd63) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'd50;
        @(negedge clk);
        wr_en = 1'b0;
        run(300, 0);

        cmp_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule